// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block is the processor-side control that enters and leaves exceptions in a small 32-bit core with a three-stage pipeline. Each cycle it looks at six request lines: normal interrupt, fast interrupt, prefetch abort, undefined instruction, software interrupt and data abort. Alongside them it sees the address of the instruction now in execute and an "instruction complete" strobe. It holds the current status word, and from that word it reads the interrupt-disable bits and the current mode.

When it accepts a request, the block picks one exception by a fixed priority. It then loads the target mode's banked link register and saved status word, switches the mode, masks interrupts, and sends fetch to the vector for that exception. The link value depends on how far the pipeline PC had moved for that exception type. When the pipeline asks for an exception return, the block applies the correction that belongs to the exception that last entered the current mode. It copies the saved status word back into the current status word and sends fetch to the corrected address.

Each exception mode has its own stack pointer and link register. These banked registers are held here, and the pair for the current mode can be read at all times. The stack pointer of the current mode can be written through a port.

Top module: `exc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no activity, status_o reads 0x000000D3. That value is supervisor mode with both interrupt-disable bits set. redirect_o, entry_o and ret_err_o are all 0.
- R2: Among pending requests, data abort wins. Fast interrupt comes next, then normal interrupt, then prefetch abort, then undefined instruction, then software interrupt. The two interrupts count only when instr_done_i is 1 and their disable bit is 0. The normal-interrupt disable bit is status bit 7, and the fast-interrupt disable bit is status bit 6.
- R3: One cycle after a request is accepted, redirect_o and entry_o are 1. redirect_pc_o is then VEC_BASE plus the vector offset: undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C. exc_kind_o carries the offset divided by 4.
- R4: On entry, the link register of the target mode is loaded with the execute address plus 8 for the two interrupts and data abort. It is loaded with the execute address plus 4 for prefetch abort, undefined instruction and software interrupt. The value is visible on cur_lr_o in the cycle after entry.
- R5: On entry, status bits 4:0 take the target mode code. The codes are fast interrupt 10001, normal interrupt 10010, supervisor 10011 (software interrupt), abort 10111 (both aborts) and undefined 11011. Bit 7 is set, and bit 6 is set on a fast-interrupt entry and kept otherwise. All other bits are kept. The previous status word goes into the target mode's saved status register.
- R6: A return sends fetch to link minus 4 after either interrupt or a prefetch abort, to link minus 0 after undefined instruction or software interrupt, and to link minus 8 after a data abort. In execute-address terms, the aborts resume at the faulting instruction and the others resume at the next one.
- R7: On a return, status_o takes the saved status word of the mode being left, and redirect_o is 1 with entry_o 0.
- R8: A return request in user mode (10000) sets ret_err_o for one cycle. It leaves status_o unchanged and gives no redirect.
- R9: If an exception is accepted in the same cycle as a return request, the entry happens and the return is dropped. The link and saved status of the mode being left stay intact.
- R10: Each mode has its own stack pointer. sp_we_i writes the pointer of the current mode, and cur_sp_o reads it. status_we_i loads status_o only in a cycle with no accepted request and no return request.
- R11: In a cycle with no eligible request and no return request, there is no redirect and status_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 1 | Normal interrupt request level |
| fiq_req_i | input | 1 | Fast interrupt request level |
| pabt_req_i | input | 1 | Tagged fetch reached execute |
| und_req_i | input | 1 | Undefined instruction in execute |
| swi_req_i | input | 1 | Software interrupt instruction in execute |
| dabt_req_i | input | 1 | Data access fault in execute |
| instr_done_i | input | 1 | Instruction in execute completes this cycle |
| ex_pc_i | input | DW | Address of the instruction in execute |
| ret_req_i | input | 1 | Exception return request |
| status_we_i | input | 1 | Load status word |
| status_wd_i | input | DW | Status word to load |
| sp_we_i | input | 1 | Write current mode stack pointer |
| sp_wd_i | input | DW | Stack pointer value |
| status_o | output | DW | Current status word |
| redirect_o | output | 1 | Fetch redirect valid |
| redirect_pc_o | output | DW | Fetch redirect target |
| entry_o | output | 1 | Redirect is an exception entry |
| exc_kind_o | output | 3 | Kind taken (vector offset / 4) |
| ret_err_o | output | 1 | Return requested in user mode |
| cur_lr_o | output | DW | Link register of current mode |
| cur_sp_o | output | DW | Stack pointer of current mode |

## Verification
An exception entry and an exception return can fall in the same cycle. This happens when a handler issues its return just as a new fault or software interrupt reaches execute. The bench provokes it by first entering the normal-interrupt mode, then raising a return request together with a software interrupt. It checks that the vector, mode and link belong to the software interrupt. It then unwinds two returns and checks that the second one still lands on the interrupted program's address and status, which shows the dropped return disturbed nothing.

// File: rtl/exc_pkg.sv
package exc_pkg;

  // kind code equals vector offset / 4
  typedef enum logic [2:0] {
    EK_NONE = 3'd0,
    EK_UND  = 3'd1,
    EK_SWI  = 3'd2,
    EK_PABT = 3'd3,
    EK_DABT = 3'd4,
    EK_IRQ  = 3'd6,
    EK_FIQ  = 3'd7
  } exc_kind_e;

  localparam int NBANK = 6;
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [4:0] MD_USR = 5'b10000;
  localparam logic [4:0] MD_FIQ = 5'b10001;
  localparam logic [4:0] MD_IRQ = 5'b10010;
  localparam logic [4:0] MD_SVC = 5'b10011;
  localparam logic [4:0] MD_ABT = 5'b10111;
  localparam logic [4:0] MD_UND = 5'b11011;

  localparam int IMASK_BIT = 7;
  localparam int FMASK_BIT = 6;

  function automatic bank_e bank_of(input logic [4:0] md);
    case (md)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;
    endcase
  endfunction

  function automatic logic [4:0] mode_of(input exc_kind_e k);
    case (k)
      EK_FIQ:          return MD_FIQ;
      EK_IRQ:          return MD_IRQ;
      EK_SWI:          return MD_SVC;
      EK_PABT, EK_DABT: return MD_ABT;
      EK_UND:          return MD_UND;
      default:         return MD_USR;
    endcase
  endfunction

  // pipeline PC is ahead by 12 or 8, link holds it minus 4
  function automatic logic [3:0] link_add(input exc_kind_e k);
    case (k)
      EK_IRQ, EK_FIQ, EK_DABT: return 4'd8;
      default:                 return 4'd4;
    endcase
  endfunction

  function automatic logic [3:0] ret_sub(input exc_kind_e k);
    case (k)
      EK_IRQ, EK_FIQ, EK_PABT: return 4'd4;
      EK_DABT:                 return 4'd8;
      default:                 return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic      dabt_i,
  input  logic      fiq_i,
  input  logic      irq_i,
  input  logic      pabt_i,
  input  logic      und_i,
  input  logic      swi_i,
  input  logic      done_i,
  input  logic      irq_mask_i,
  input  logic      fiq_mask_i,
  output exc_kind_e kind_o
);

  logic fiq_ok, irq_ok;

  assign fiq_ok = fiq_i & done_i & ~fiq_mask_i;
  assign irq_ok = irq_i & done_i & ~irq_mask_i;

  always_comb begin
    if (dabt_i)      kind_o = EK_DABT;
    else if (fiq_ok) kind_o = EK_FIQ;
    else if (irq_ok) kind_o = EK_IRQ;
    else if (pabt_i) kind_o = EK_PABT;
    else if (und_i)  kind_o = EK_UND;
    else if (swi_i)  kind_o = EK_SWI;
    else             kind_o = EK_NONE;
  end

endmodule

// File: rtl/exc_bank.sv
module exc_bank
  import exc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ent_we_i,
  input  bank_e         ent_idx_i,
  input  logic [DW-1:0] ent_lr_i,
  input  logic [DW-1:0] ent_spsr_i,
  input  logic [3:0]    ent_corr_i,
  input  logic          sp_we_i,
  input  bank_e         sp_idx_i,
  input  logic [DW-1:0] sp_wd_i,
  input  bank_e         rd_idx_i,
  output logic [DW-1:0] rd_lr_o,
  output logic [DW-1:0] rd_sp_o,
  output logic [DW-1:0] rd_spsr_o,
  output logic [3:0]    rd_corr_o
);

  logic [DW-1:0] lr_all   [NBANK];
  logic [DW-1:0] sp_all   [NBANK];
  logic [DW-1:0] spsr_all [NBANK];
  logic [3:0]    corr_all [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic          ent_hit, sp_hit;
    logic [DW-1:0] lr_q, sp_q;

    assign ent_hit = ent_we_i && (ent_idx_i == bank_e'(b));
    assign sp_hit  = sp_we_i  && (sp_idx_i  == bank_e'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lr_q <= '0;
        sp_q <= '0;
      end else begin
        if (ent_hit) lr_q <= ent_lr_i;
        if (sp_hit)  sp_q <= sp_wd_i;
      end
    end

    assign lr_all[b] = lr_q;
    assign sp_all[b] = sp_q;

    if (b == 0) begin : g_usr
      assign spsr_all[b] = '0;
      assign corr_all[b] = '0;
    end else begin : g_exc
      logic [DW-1:0] spsr_q;
      logic [3:0]    corr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          spsr_q <= '0;
          corr_q <= '0;
        end else if (ent_hit) begin
          spsr_q <= ent_spsr_i;
          corr_q <= ent_corr_i;
        end
      end
      assign spsr_all[b] = spsr_q;
      assign corr_all[b] = corr_q;
    end
  end

  assign rd_lr_o   = lr_all[rd_idx_i];
  assign rd_sp_o   = sp_all[rd_idx_i];
  assign rd_spsr_o = spsr_all[rd_idx_i];
  assign rd_corr_o = corr_all[rd_idx_i];

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req_i,
  input  logic          fiq_req_i,
  input  logic          pabt_req_i,
  input  logic          und_req_i,
  input  logic          swi_req_i,
  input  logic          dabt_req_i,
  input  logic          instr_done_i,
  input  logic [DW-1:0] ex_pc_i,
  input  logic          ret_req_i,
  input  logic          status_we_i,
  input  logic [DW-1:0] status_wd_i,
  input  logic          sp_we_i,
  input  logic [DW-1:0] sp_wd_i,
  output logic [DW-1:0] status_o,
  output logic          redirect_o,
  output logic [DW-1:0] redirect_pc_o,
  output logic          entry_o,
  output logic [2:0]    exc_kind_o,
  output logic          ret_err_o,
  output logic [DW-1:0] cur_lr_o,
  output logic [DW-1:0] cur_sp_o
);

  localparam logic [DW-1:0] RESET_STATUS =
    DW'({1'b1, 1'b1, 1'b0, MD_SVC});

  exc_kind_e     kind;
  bank_e         cur_bank, tgt_bank;
  logic          take, do_ret, bad_ret;
  logic [4:0]    tgt_mode;
  logic [DW-1:0] rd_lr, rd_sp, rd_spsr;
  logic [3:0]    rd_corr;

  logic [DW-1:0] status_q, status_d;
  logic          redir_q, redir_d, entry_q, entry_d, err_q, err_d;
  logic [DW-1:0] rpc_q, rpc_d;
  logic [2:0]    kind_q, kind_d;

  exc_arbiter u_arb (
    .dabt_i     (dabt_req_i),
    .fiq_i      (fiq_req_i),
    .irq_i      (irq_req_i),
    .pabt_i     (pabt_req_i),
    .und_i      (und_req_i),
    .swi_i      (swi_req_i),
    .done_i     (instr_done_i),
    .irq_mask_i (status_q[IMASK_BIT]),
    .fiq_mask_i (status_q[FMASK_BIT]),
    .kind_o     (kind)
  );

  assign cur_bank = bank_of(status_q[4:0]);
  assign tgt_mode = mode_of(kind);
  assign tgt_bank = bank_of(tgt_mode);
  assign take     = (kind != EK_NONE);
  assign do_ret   = ret_req_i && !take && (cur_bank != BK_USR);
  assign bad_ret  = ret_req_i && !take && (cur_bank == BK_USR);

  exc_bank #(.DW(DW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_we_i   (take),
    .ent_idx_i  (tgt_bank),
    .ent_lr_i   (ex_pc_i + DW'(link_add(kind))),
    .ent_spsr_i (status_q),
    .ent_corr_i (ret_sub(kind)),
    .sp_we_i    (sp_we_i),
    .sp_idx_i   (cur_bank),
    .sp_wd_i    (sp_wd_i),
    .rd_idx_i   (cur_bank),
    .rd_lr_o    (rd_lr),
    .rd_sp_o    (rd_sp),
    .rd_spsr_o  (rd_spsr),
    .rd_corr_o  (rd_corr)
  );

  // next-state
  always_comb begin
    status_d = status_q;
    if (take) begin
      status_d[4:0]      = tgt_mode;
      status_d[IMASK_BIT] = 1'b1;
      if (kind == EK_FIQ) status_d[FMASK_BIT] = 1'b1;
    end else if (do_ret) begin
      status_d = rd_spsr;
    end else if (status_we_i && !ret_req_i) begin
      status_d = status_wd_i;
    end

    redir_d = take || do_ret;
    entry_d = take;
    err_d   = bad_ret;
    kind_d  = take ? kind : EK_NONE;
    if (take) rpc_d = VEC_BASE[DW-1:0] | DW'({kind, 2'b00});
    else if (do_ret) rpc_d = rd_lr - DW'(rd_corr);
    else rpc_d = rpc_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= RESET_STATUS;
      redir_q  <= 1'b0;
      entry_q  <= 1'b0;
      err_q    <= 1'b0;
      kind_q   <= EK_NONE;
      rpc_q    <= '0;
    end else begin
      status_q <= status_d;
      redir_q  <= redir_d;
      entry_q  <= entry_d;
      err_q    <= err_d;
      kind_q   <= kind_d;
      rpc_q    <= rpc_d;
    end
  end

  assign status_o      = status_q;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = rpc_q;
  assign entry_o       = entry_q;
  assign exc_kind_o    = kind_q;
  assign ret_err_o     = err_q;
  assign cur_lr_o      = rd_lr;
  assign cur_sp_o      = rd_sp;

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_req_i,
  input logic          fiq_req_i,
  input logic          pabt_req_i,
  input logic          und_req_i,
  input logic          swi_req_i,
  input logic          dabt_req_i,
  input logic          ret_req_i,
  input logic [DW-1:0] ex_pc_i,
  input logic [DW-1:0] status_o,
  input logic          redirect_o,
  input logic [DW-1:0] redirect_pc_o,
  input logic          entry_o,
  input logic [2:0]    exc_kind_o,
  input logic          ret_err_o,
  input logic [DW-1:0] cur_lr_o
);

  AST_ENTRY_SETS_IMASK: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> status_o[7]); // R5

  AST_FIQ_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && exc_kind_o == 3'd7) |-> (status_o[6] && status_o[4:0] == 5'b10001)); // R5

  AST_LINK_LATE_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && (exc_kind_o == 3'd4 || exc_kind_o == 3'd6 || exc_kind_o == 3'd7))
      |-> cur_lr_o == $past(ex_pc_i) + DW'(8)); // R4

  AST_LINK_EARLY_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && (exc_kind_o == 3'd1 || exc_kind_o == 3'd2 || exc_kind_o == 3'd3))
      |-> cur_lr_o == $past(ex_pc_i) + DW'(4)); // R4

  AST_ENTRY_HAS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (redirect_o && redirect_pc_o[1:0] == 2'b00)); // R3

  AST_USER_RETURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err_o |-> (!redirect_o && status_o == $past(status_o))); // R8

  AST_MASKED_IRQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_i && status_o[7] && !fiq_req_i && !pabt_req_i && !und_req_i &&
     !swi_req_i && !dabt_req_i && !ret_req_i) |=> !redirect_o); // R2

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_err_o && entry_o)); // R9

endmodule

bind exc_ctrl exc_ctrl_chk #(.DW(DW)) u_exc_ctrl_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .irq_req_i     (irq_req_i),
  .fiq_req_i     (fiq_req_i),
  .pabt_req_i    (pabt_req_i),
  .und_req_i     (und_req_i),
  .swi_req_i     (swi_req_i),
  .dabt_req_i    (dabt_req_i),
  .ret_req_i     (ret_req_i),
  .ex_pc_i       (ex_pc_i),
  .status_o      (status_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .entry_o       (entry_o),
  .exc_kind_o    (exc_kind_o),
  .ret_err_o     (ret_err_o),
  .cur_lr_o      (cur_lr_o)
);

// File: tb/tb_exc_ctrl.sv
`timescale 1ns/1ps
module tb_exc_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_req, fiq_req, pabt_req, und_req, swi_req, dabt_req;
  logic        done, ret_req, status_we, sp_we;
  logic [31:0] ex_pc, status_wd, sp_wd;
  logic [31:0] status_o, redirect_pc_o, cur_lr_o, cur_sp_o;
  logic        redirect_o, entry_o, ret_err_o;
  logic [2:0]  exc_kind_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  exc_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .irq_req_i(irq_req), .fiq_req_i(fiq_req), .pabt_req_i(pabt_req),
    .und_req_i(und_req), .swi_req_i(swi_req), .dabt_req_i(dabt_req),
    .instr_done_i(done), .ex_pc_i(ex_pc), .ret_req_i(ret_req),
    .status_we_i(status_we), .status_wd_i(status_wd),
    .sp_we_i(sp_we), .sp_wd_i(sp_wd),
    .status_o(status_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .entry_o(entry_o), .exc_kind_o(exc_kind_o), .ret_err_o(ret_err_o),
    .cur_lr_o(cur_lr_o), .cur_sp_o(cur_sp_o)
  );

  // req order: {dabt, fiq, irq, pabt, und, swi}
  typedef struct packed {
    logic [5:0]  req;
    logic        done;
    logic [7:0]  st;
    logic [31:0] pc;
    logic [7:0]  vec;
    logic [4:0]  mode;
    logic [3:0]  lro;
    logic [3:0]  reto;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{6'b000001, 1'b0, 8'h10, 32'h0000_0100, 8'h08, 5'h13, 4'd4, 4'd4},
    '{6'b000010, 1'b0, 8'h10, 32'h0000_0200, 8'h04, 5'h1B, 4'd4, 4'd4},
    '{6'b000100, 1'b0, 8'h10, 32'h0000_0300, 8'h0C, 5'h17, 4'd4, 4'd0},
    '{6'b001000, 1'b1, 8'h10, 32'h0000_0400, 8'h18, 5'h12, 4'd8, 4'd4},
    '{6'b010000, 1'b1, 8'h10, 32'h0000_0500, 8'h1C, 5'h11, 4'd8, 4'd4},
    '{6'b100000, 1'b0, 8'h10, 32'h0000_0600, 8'h10, 5'h17, 4'd8, 4'd0},
    '{6'b111111, 1'b1, 8'h10, 32'h0000_0700, 8'h10, 5'h17, 4'd8, 4'd0},
    '{6'b011100, 1'b1, 8'h10, 32'h0000_0800, 8'h1C, 5'h11, 4'd8, 4'd4},
    '{6'b001100, 1'b1, 8'h90, 32'h0000_0900, 8'h0C, 5'h17, 4'd4, 4'd0},
    '{6'b001010, 1'b0, 8'h10, 32'h0000_0A00, 8'h04, 5'h1B, 4'd4, 4'd4},
    '{6'b010001, 1'b1, 8'h50, 32'h0000_0B00, 8'h08, 5'h13, 4'd4, 4'd4},
    '{6'b001000, 1'b1, 8'h13, 32'h0000_0C00, 8'h18, 5'h12, 4'd8, 4'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIAL_MARK", tag);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_in();
    {dabt_req, fiq_req, irq_req, pabt_req, und_req, swi_req} = '0;
    done = 0; ret_req = 0; status_we = 0; sp_we = 0;
  endtask

  task automatic set_status(input logic [31:0] v);
    status_wd = v; status_we = 1; tick(); status_we = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clear_in(); ex_pc = '0; status_wd = '0; sp_wd = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk("R1 status in reset", status_o, 32'hD3);
    rst_n = 1;
    tick();
    chk("R1 status", status_o, 32'hD3);
    chk("R1 flags", {29'd0, redirect_o, entry_o, ret_err_o}, 32'd0);

    // table walk: R2..R7
    for (int i = 0; i < NV; i++) begin
      logic [31:0] st_exp;
      set_status({24'd0, TBL[i].st});
      {dabt_req, fiq_req, irq_req, pabt_req, und_req, swi_req} = TBL[i].req;
      done = TBL[i].done; ex_pc = TBL[i].pc;
      tick();
      clear_in();
      st_exp = {24'd0, 1'b1, TBL[i].st[6] | (TBL[i].mode == 5'h11), TBL[i].st[5], TBL[i].mode};
      chk("R2/R3 entry flags", {30'd0, redirect_o, entry_o}, 32'd3);
      chk("R3 vector", redirect_pc_o, {24'd0, TBL[i].vec});
      chk("R3 kind", {29'd0, exc_kind_o}, {29'd0, TBL[i].vec[4:2]});
      chk("R5 status after entry", status_o, st_exp);
      chk("R4 link", cur_lr_o, TBL[i].pc + {28'd0, TBL[i].lro});
      ret_req = 1;
      tick();
      ret_req = 0;
      chk("R7 return flags", {30'd0, redirect_o, entry_o}, 32'd2);
      chk("R6 return pc", redirect_pc_o, TBL[i].pc + {28'd0, TBL[i].reto});
      chk("R7 restored status", status_o, {24'd0, TBL[i].st});
    end

    // R8 user-mode return
    set_status(32'h10);
    ret_req = 1; tick(); ret_req = 0;
    chk("R8 err", {31'd0, ret_err_o}, 32'd1);
    chk("R8 no redirect", {31'd0, redirect_o}, 32'd0);
    chk("R8 status kept", status_o, 32'h10);

    // R11 / R2 masked and not-done interrupts
    set_status(32'h90);
    irq_req = 1; done = 1; tick(); clear_in();
    chk("R2 masked irq", {31'd0, redirect_o}, 32'd0);
    chk("R11 status kept", status_o, 32'h90);
    set_status(32'h10);
    irq_req = 1; fiq_req = 1; done = 0; tick(); clear_in();
    chk("R2 irq needs done", {31'd0, redirect_o}, 32'd0);
    chk("R11 status kept2", status_o, 32'h10);

    // R9 entry and return in same cycle
    irq_req = 1; done = 1; ex_pc = 32'h200; tick(); clear_in();
    chk("R9 irq entered", status_o, 32'h92);
    ret_req = 1; swi_req = 1; ex_pc = 32'h300; tick(); clear_in();
    chk("R9 entry wins pc", redirect_pc_o, 32'h08);
    chk("R9 entry flag", {31'd0, entry_o}, 32'd1);
    chk("R9 svc status", status_o, 32'h93);
    chk("R9 svc link", cur_lr_o, 32'h304);
    ret_req = 1; tick(); ret_req = 0;
    chk("R9 back to irq pc", redirect_pc_o, 32'h304);
    chk("R9 back to irq status", status_o, 32'h92);
    ret_req = 1; tick(); ret_req = 0;
    chk("R9 irq return intact pc", redirect_pc_o, 32'h204);
    chk("R9 irq return status", status_o, 32'h10);

    // R10 banked stack pointers, status write blocked by return
    set_status(32'h13);
    sp_wd = 32'hAAAA; sp_we = 1; tick(); sp_we = 0;
    set_status(32'h17);
    sp_wd = 32'hBBBB; sp_we = 1; tick(); sp_we = 0;
    set_status(32'h13);
    chk("R10 svc sp", cur_sp_o, 32'hAAAA);
    set_status(32'h17);
    chk("R10 abt sp", cur_sp_o, 32'hBBBB);
    set_status(32'h10);
    status_wd = 32'h13; status_we = 1; ret_req = 1; tick(); clear_in();
    chk("R10 write blocked by return", status_o, 32'h10);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule